// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debugger reach memory and peripherals without involving the processor. It holds three registers that are written and read through a small debug register port: a control register, an address register and a data register. Accesses to these registers start single transfers on a 32-bit master bus. Reading or writing through the address or data register can start a read or a write. Byte, halfword and word sizes are supported. Sub-word write data is copied onto every byte lane. Sub-word read data is taken from the lane selected by the low address bits and zero-extended.

Error flags are sticky. While any of them is set, no transfer starts. The software clears them by writing ones to their bits. A master-ID output is high for the whole time that a transfer started by this engine is in progress, so the system can tell debugger traffic apart from processor traffic.

The request side of the bus follows valid/ready rules. Once `bus_req_valid` is raised, it stays high and the address, data, size and direction stay unchanged until a cycle in which `bus_req_ready` is also high. Only one transfer is outstanding at a time. The response arrives as a single-cycle `bus_rsp_valid` pulse, on any cycle after the request is accepted. The engine cannot refuse the response.

Top module: `sba_engine`

Register selector `reg_sel`: 0 selects control, 1 selects address, 2 selects data.

Control register fields:

| Bits | Field | Access |
|------|-------|--------|
| [2:0] | Access size: 0 = byte, 1 = halfword, 2 = word, 3 to 7 = unsupported | read/write |
| 3 | Read when the address register is written | read/write |
| 4 | Read when the data register is read | read/write |
| 5 | Auto-increment | read/write |
| 6 | Busy | read-only |
| [9:7] | Error code | write 1 to clear |
| 10 | Busy-error flag | write 1 to clear |

## Requirements
- R1: After reset the control register reads 0x002 (word size, all flags clear, not busy, no errors). The address and data registers read 0. Neither `bus_req_valid` nor `bus_master_id` is high.
- R2: A transfer starts when any of the following happens while the engine is idle and no error flag is set:
  - the data register is written (this starts a write);
  - the address register is written while control bit 3 is set (this starts a read);
  - the data register is read while control bit 4 is set (this starts a read).
- R3: While the error code is nonzero or the busy-error flag (bit 10) is set, no register access starts a bus request.
- R4: For halfword size, address bit 0 must be zero. For word size, address bits [1:0] must be zero. If they are not, the error code becomes 3 and no request is issued. When the trigger is an address write, the check uses the newly written address.
- R5: A size value of 3 or more sets the error code to 4 when a transfer is triggered, and no request is issued.
- R6: On a write, `bus_req_wdata` carries the data byte on all four lanes for byte size, the low halfword on both halves for halfword size, and the whole word for word size.
- R7: A successful read loads the data register with the selected lane, zero-extended:
  - byte size: bits [8*a+7:8*a] of the bus word, where a is address bits [1:0];
  - halfword size: bits [31:16] if address bit 1 is set, otherwise bits [15:0];
  - word size: the whole word.
- R8: A response with `bus_rsp_err` set makes the error code 2. After a failed read, the data register keeps its previous value.
- R9: Any read or write of the address or data register while busy sets the busy-error flag. Apart from setting that flag, the access has no effect.
- R10: Writing a 1 to a bit of the error code (bits [9:7]) clears that bit. Writing a 1 to bit 10 clears the busy-error flag. Writing 0 to these bits leaves them unchanged.
- R11: With auto-increment set (bit 5), the address advances by 1, 2 or 4 (the access size) after each successful transfer. It does not change after a failed transfer.
- R12: `bus_master_id` is high from the cycle a request is raised until its response is taken, and low while the engine is idle.
- R13: While `bus_req_valid` is high and `bus_req_ready` is low, the request stays valid and its address and write data do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (has side effects on the data register) |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Value of the selected register |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_req_addr | output | AW | Byte address |
| bus_req_wdata | output | 32 | Lane-replicated write data |
| bus_rsp_valid | input | 1 | Response pulse |
| bus_rsp_err | input | 1 | Response carries a bus error |
| bus_rsp_rdata | input | 32 | Read data word |
| bus_master_id | output | 1 | High during engine-initiated bus cycles |

## Verification
A triggering register access takes effect at the clock edge where its strobe is high:
- Size and alignment errors, and the busy-error flag, are visible right after that edge.
- `bus_req_valid` and `bus_master_id` also rise right after that edge.

The bench's memory model accepts the request at the first edge with ready high and pulses the response one edge later. The data register, the address increment, the error code and the busy flag all update at that response edge.

The bench drives strobes at falling edges and reads outputs one time unit later. It never assumes a fixed latency: before each result check it polls the busy bit until it drops. Checks for "no transfer" compare the model's handshake count before and after the stimulus.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUS   = 3'd2;
  localparam logic [2:0] ERR_ALIGN = 3'd3;
  localparam logic [2:0] ERR_SIZE  = 3'd4;

  localparam int F_RDADDR  = 3;
  localparam int F_RDDATA  = 4;
  localparam int F_AUTOINC = 5;
  localparam int F_ERR_LO  = 7;
  localparam int F_BUSYERR = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} sba_state_t;
endpackage

// File: rtl/sba_gate.sv
module sba_gate #(
  parameter int AW = 32
) (
  input  logic          trig,
  input  logic [2:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    err_q,
  input  logic          busyerr_q,
  output logic          go,
  output logic          flag_err,
  output logic [2:0]    err_code
);
  import sba_pkg::*;
  logic blocked, bad_size, misal;

  always_comb begin
    blocked  = (err_q != ERR_NONE) || busyerr_q;
    bad_size = size > 3'd2;
    unique case (size)
      3'd1:    misal = addr[0];
      3'd2:    misal = |addr[1:0];
      default: misal = 1'b0;
    endcase
    go       = trig && !blocked && !bad_size && !misal;
    flag_err = trig && !blocked && (bad_size || misal);
    err_code = bad_size ? ERR_SIZE : ERR_ALIGN;
  end
endmodule

// File: rtl/sba_lanes.sv
module sba_lanes #(
  parameter int DW = 32
) (
  input  logic [1:0]    size,
  input  logic [1:0]    addr_lo,
  input  logic [DW-1:0] wr_word,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] wr_rep,
  output logic [DW-1:0] rd_pick
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;
  logic [DW-1:0] rb_rep, rh_rep;
  logic [DW-1:0] shifted;

  for (genvar b = 0; b < NB; b++) begin : g_brep
    assign rb_rep[b*8 +: 8] = wr_word[7:0];
  end
  for (genvar h = 0; h < NH; h++) begin : g_hrep
    assign rh_rep[h*16 +: 16] = wr_word[15:0];
  end

  always_comb begin
    unique case (size)
      2'd0:    wr_rep = rb_rep;
      2'd1:    wr_rep = rh_rep;
      default: wr_rep = wr_word;
    endcase
    shifted = bus_rdata >> {addr_lo, 3'b000};
    unique case (size)
      2'd0:    rd_pick = {{(DW-8){1'b0}}, shifted[7:0]};
      2'd1:    rd_pick = {{(DW-16){1'b0}}, shifted[15:0]};
      default: rd_pick = bus_rdata;
    endcase
  end
endmodule

// File: rtl/sba_engine.sv
module sba_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic          bus_req_write,
  output logic [1:0]    bus_req_size,
  output logic [AW-1:0] bus_req_addr,
  output logic [31:0]   bus_req_wdata,
  input  logic          bus_rsp_valid,
  input  logic          bus_rsp_err,
  input  logic [31:0]   bus_rsp_rdata,
  output logic          bus_master_id
);
  import sba_pkg::*;
  localparam int DW = 32;

  sba_state_t    st_q;
  logic [AW-1:0] addr_q, req_addr_q, chk_addr;
  logic [DW-1:0] data_q, rd_pick, wr_rep;
  logic [2:0]    size_q, err_q, gate_code;
  logic [1:0]    req_size_q;
  logic          req_wr_q, rdaddr_q, rddata_q, autoinc_q, busyerr_q;
  logic          busy, in_rsp, hit_ad, busy_hit, wr_ctrl, wr_addr, wr_data, rd_data;
  logic          trig, go, gate_err;

  always_comb begin
    busy     = st_q != ST_IDLE;
    in_rsp   = st_q == ST_RSP;
    hit_ad   = (reg_wr_en || reg_rd_en) && (reg_sel == SEL_ADDR || reg_sel == SEL_DATA);
    busy_hit = hit_ad && busy;
    wr_ctrl  = reg_wr_en && reg_sel == SEL_CTRL;
    wr_addr  = reg_wr_en && reg_sel == SEL_ADDR && !busy;
    wr_data  = reg_wr_en && reg_sel == SEL_DATA && !busy;
    rd_data  = reg_rd_en && !reg_wr_en && reg_sel == SEL_DATA && !busy;
    trig     = (wr_addr && rdaddr_q) || wr_data || (rd_data && rddata_q);
    chk_addr = wr_addr ? reg_wdata[AW-1:0] : addr_q;
  end

  sba_gate #(.AW(AW)) u_gate (
    .trig      (trig),
    .size      (size_q),
    .addr      (chk_addr),
    .err_q     (err_q),
    .busyerr_q (busyerr_q),
    .go        (go),
    .flag_err  (gate_err),
    .err_code  (gate_code)
  );

  sba_lanes #(.DW(DW)) u_lanes (
    .size      (req_size_q),
    .addr_lo   (req_addr_q[1:0]),
    .wr_word   (data_q),
    .bus_rdata (bus_rsp_rdata),
    .wr_rep    (wr_rep),
    .rd_pick   (rd_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      size_q     <= 3'd2;
      rdaddr_q   <= 1'b0;
      rddata_q   <= 1'b0;
      autoinc_q  <= 1'b0;
      err_q      <= ERR_NONE;
      busyerr_q  <= 1'b0;
      req_addr_q <= '0;
      req_size_q <= 2'd2;
      req_wr_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        size_q    <= reg_wdata[2:0];
        rdaddr_q  <= reg_wdata[F_RDADDR];
        rddata_q  <= reg_wdata[F_RDDATA];
        autoinc_q <= reg_wdata[F_AUTOINC];
        err_q     <= err_q & ~reg_wdata[F_ERR_LO +: 3];
        busyerr_q <= busyerr_q & ~reg_wdata[F_BUSYERR];
      end
      if (wr_addr) addr_q <= reg_wdata[AW-1:0];
      if (wr_data) data_q <= reg_wdata;
      if (busy_hit) busyerr_q <= 1'b1;
      if (gate_err) err_q <= gate_code;
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q       <= ST_REQ;
          req_addr_q <= chk_addr;
          req_size_q <= size_q[1:0];
          req_wr_q   <= wr_data;
        end
        ST_REQ: if (bus_req_ready) st_q <= ST_RSP;
        ST_RSP: if (bus_rsp_valid) begin
          st_q <= ST_IDLE;
          if (bus_rsp_err) begin
            err_q <= ERR_BUS;
          end else begin
            if (!req_wr_q) data_q <= rd_pick;
            if (autoinc_q) addr_q <= req_addr_q + (AW'(1) << req_size_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: reg_rdata = {21'd0, busyerr_q, err_q, busy, autoinc_q, rddata_q, rdaddr_q, size_q};
      SEL_ADDR: reg_rdata = 32'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
    bus_req_valid = st_q == ST_REQ;
    bus_req_write = req_wr_q;
    bus_req_size  = req_size_q;
    bus_req_addr  = req_addr_q;
    bus_req_wdata = wr_rep;
    bus_master_id = busy;
  end
endmodule

// File: rtl/sba_engine_chk.sv
module sba_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req_valid,
  input logic          bus_req_ready,
  input logic [AW-1:0] bus_req_addr,
  input logic [31:0]   bus_req_wdata,
  input logic          bus_master_id,
  input logic          bus_rsp_valid,
  input logic          bus_rsp_err,
  input logic          busy,
  input logic          in_rsp,
  input logic [2:0]    err_q,
  input logic          busyerr_q,
  input logic [31:0]   data_q
);
  assert_mid_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> bus_master_id);

  assert_mid_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_master_id);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata));

  assert_err_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (err_q != 3'd0 || busyerr_q) |=> !bus_req_valid);

  assert_err_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_rsp && bus_rsp_valid && bus_rsp_err |=> $stable(data_q) && err_q == 3'd2);
endmodule

bind sba_engine sba_engine_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_addr  (bus_req_addr),
  .bus_req_wdata (bus_req_wdata),
  .bus_master_id (bus_master_id),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_err   (bus_rsp_err),
  .busy          (busy),
  .in_rsp        (in_rsp),
  .err_q         (err_q),
  .busyerr_q     (busyerr_q),
  .data_q        (data_q)
);

// File: tb/tb_sba_engine.sv
module tb_sba_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] RDA = 32'h8, RDD = 32'h10, AI = 32'h20;
  localparam logic [31:0] ERRW1C = 32'h380, BEW1C = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic bus_req_valid, bus_req_ready, bus_req_write, bus_master_id;
  logic [1:0] bus_req_size;
  logic [AW-1:0] bus_req_addr;
  logic [31:0] bus_req_wdata;
  logic bus_rsp_valid = 0, bus_rsp_err = 0;
  logic [31:0] bus_rsp_rdata = 0;
  logic stall = 0;

  int n_tests = 0, n_fail = 0, cyc = 0, hs_count = 0, mid_bad = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  logic [31:0] last_wdata = 0;

  assign bus_req_ready = !stall;
  always #(CLK_PERIOD/2) clk = ~clk;

  sba_engine #(.AW(AW)) dut (.*);

  function automatic logic [31:0] init_word(int i);
    return (32'(i) * 32'h01030507) ^ 32'h5A3C96E1;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, int sz, logic [1:0] a);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (sz == 2 || (sz == 1 && b[1] == a[1]) || (sz == 0 && b[1:0] == a)) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  initial for (int i = 0; i < 16; i++) begin mem[i] = init_word(i); shadow[i] = init_word(i); end

  // bus memory model: one-cycle response, error for address bit 8
  always @(posedge clk) begin
    bus_rsp_valid <= 1'b0;
    if (rst_n && bus_req_valid && bus_req_ready) begin
      hs_count <= hs_count + 1;
      if (!bus_master_id) mid_bad <= mid_bad + 1;
      last_wdata    <= bus_req_wdata;
      bus_rsp_valid <= 1'b1;
      bus_rsp_err   <= bus_req_addr[8];
      bus_rsp_rdata <= bus_req_addr[8] ? 32'hDEADBEEF : mem[bus_req_addr[5:2]];
      if (bus_req_write && !bus_req_addr[8])
        mem[bus_req_addr[5:2]] <= merge(mem[bus_req_addr[5:2]], bus_req_wdata, int'(bus_req_size), bus_req_addr[1:0]);
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [31:0] val);
    @(negedge clk); reg_sel = sel; reg_wdata = val; reg_wr_en = 1;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic reg_rd(logic [1:0] sel, output logic [31:0] val);
    @(negedge clk); reg_sel = sel; reg_rd_en = 1; #1 val = reg_rdata;
    @(negedge clk); reg_rd_en = 0;
  endtask

  task automatic peek(logic [1:0] sel, output logic [31:0] val);
    @(negedge clk); reg_sel = sel; #1 val = reg_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [31:0] c;
    for (int k = 0; k < 40; k++) begin
      peek(2'd0, c);
      if (!c[6]) return;
    end
    chk({tag, " busy timeout"}, 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] rep(logic [31:0] d, int sz);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] pick(logic [31:0] w, int sz, int off);
    if (sz == 0) return (w >> (off * 8)) & 32'hFF;
    if (sz == 1) return (w >> (off * 8)) & 32'hFFFF;
    return w;
  endfunction

  initial begin
    logic [31:0] v, d0;
    int h0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid after reset", 32'(bus_req_valid), 0);
    chk("R1 master id after reset", 32'(bus_master_id), 0);
    rst_n = 1;
    peek(2'd0, v); chk("R1 ctrl reset", v, 32'h2);
    peek(2'd1, v); chk("R1 addr reset", v, 0);
    peek(2'd2, v); chk("R1 data reset", v, 0);

    // R6/R7 sweep: every size and legal offset, write then read back
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off += (1 << sz)) begin
        logic [31:0] p = 32'hA0B1C2D3 ^ 32'((sz << 12) | (off << 4) | off);
        reg_wr(2'd0, 32'(sz));
        reg_wr(2'd1, 32'h08 + 32'(off));
        h0 = hs_count;
        reg_wr(2'd2, p);
        wait_idle("R2");
        chk("R2 data write starts transfer", 32'(hs_count - h0), 1);
        chk("R6 replicated write data", last_wdata, rep(p, sz));
        shadow[2] = merge(shadow[2], rep(p, sz), sz, 2'(off));
        reg_wr(2'd0, 32'(sz) | RDA);
        reg_wr(2'd1, 32'h08 + 32'(off));
        wait_idle("R7");
        peek(2'd2, v); chk("R7 lane pick", v, pick(shadow[2], sz, off));
        peek(2'd0, v); chk("R7 no error", 32'(v[9:7]), 0);
      end
    end

    // R4: misaligned fresh address, then aligned fresh address after stale bad one
    reg_wr(2'd0, 32'h2 | RDA);
    h0 = hs_count;
    reg_wr(2'd1, 32'h12);
    peek(2'd0, v); chk("R4 align error code", 32'(v[9:7]), 3);
    chk("R4 no bus on misalign", 32'(hs_count - h0), 0);
    reg_wr(2'd0, 32'h2 | RDA);
    peek(2'd0, v); chk("R10 zero write keeps error", 32'(v[9:7]), 3);
    reg_wr(2'd0, 32'h2 | RDA | ERRW1C);
    peek(2'd0, v); chk("R10 W1C clears error", 32'(v[9:7]), 0);
    reg_wr(2'd1, 32'h14);
    wait_idle("R4");
    peek(2'd0, v); chk("R4 fresh aligned address ok", 32'(v[9:7]), 0);
    peek(2'd2, v); chk("R4 read data", v, shadow[5]);

    // R5 and R3
    reg_wr(2'd0, 32'h3 | RDA);
    h0 = hs_count;
    reg_wr(2'd1, 32'h10);
    peek(2'd0, v); chk("R5 size error code", 32'(v[9:7]), 4);
    reg_wr(2'd0, 32'h2 | RDA);
    reg_wr(2'd2, 32'h55);
    reg_wr(2'd1, 32'h10);
    chk("R3 error blocks transfers", 32'(hs_count - h0), 0);
    peek(2'd0, v); chk("R3 error kept", 32'(v[9:7]), 4);
    reg_wr(2'd0, 32'h2 | ERRW1C);

    // R8: bus error on read
    reg_wr(2'd1, 32'h04);
    reg_wr(2'd0, 32'h2 | RDA | AI);
    peek(2'd2, d0);
    reg_wr(2'd1, 32'h100);
    wait_idle("R8");
    peek(2'd0, v); chk("R8 bus error code", 32'(v[9:7]), 2);
    peek(2'd2, v); chk("R8 data kept on failed read", v, d0);
    peek(2'd1, v); chk("R11 no increment after error", v, 32'h100);
    reg_wr(2'd0, 32'h2 | ERRW1C);

    // R11: auto-increment with read-on-data
    reg_wr(2'd0, 32'h2 | RDD | AI);
    reg_wr(2'd1, 32'h20);
    for (int k = 0; k < 3; k++) begin
      reg_rd(2'd2, v);
      wait_idle("R11");
      peek(2'd2, v); chk("R2 read-on-data fetch", v, shadow[8 + k]);
      peek(2'd1, v); chk("R11 word increment", v, 32'h24 + 32'(4 * k));
    end
    reg_wr(2'd0, 32'h1 | RDD | AI);
    reg_wr(2'd1, 32'h22);
    reg_rd(2'd2, v);
    wait_idle("R11h");
    peek(2'd2, v); chk("R7 halfword high lane", v, pick(shadow[8], 1, 2));
    peek(2'd1, v); chk("R11 half increment", v, 32'h24);

    // R9/R12/R13: stalled bus and access while busy
    reg_wr(2'd0, 32'h2);
    reg_wr(2'd1, 32'h30);
    h0 = hs_count;
    stall = 1;
    reg_wr(2'd2, 32'h11223344);
    #1;
    chk("R12 master id while requesting", 32'(bus_master_id), 1);
    chk("R13 valid raised", 32'(bus_req_valid), 1);
    reg_wr(2'd1, 32'h34);
    reg_wr(2'd2, 32'h99);
    #1;
    chk("R13 request held", 32'(bus_req_valid), 1);
    chk("R13 address stable", bus_req_addr, 32'h30);
    chk("R13 data stable", bus_req_wdata, 32'h11223344);
    stall = 0;
    wait_idle("R9");
    #1;
    chk("R12 master id low when idle", 32'(bus_master_id), 0);
    shadow[12] = 32'h11223344;
    peek(2'd0, v); chk("R9 busy error set", 32'(v[10]), 1);
    peek(2'd1, v); chk("R9 addr untouched", v, 32'h30);
    peek(2'd2, v); chk("R9 data untouched", v, 32'h11223344);
    chk("R9 single transfer", 32'(hs_count - h0), 1);
    reg_wr(2'd2, 32'h77);
    chk("R3 busy error blocks", 32'(hs_count - h0), 1);
    reg_wr(2'd0, 32'h2 | BEW1C);
    peek(2'd0, v); chk("R10 busy error cleared", 32'(v[10]), 0);
    reg_wr(2'd0, 32'h2 | RDA);
    reg_wr(2'd1, 32'h30);
    wait_idle("R9r");
    peek(2'd2, v); chk("R9 memory holds first write", v, shadow[12]);
    chk("R12 master id at each handshake", 32'(mid_bad), 0);
    summary();
  end
endmodule